// File: doc/BRIEF.md
# Flash Read Burst Buffer Controller

This block sits between a 32-bit system bus and a flash array and serves read requests through two line buffers. Each line holds four 32-bit words. The most significant bit of the word address splits the array into a lower and an upper block group, and each group has its own buffer. A read that misses its group's buffer fetches the full line from the array. This takes a programmable number of wait clocks. Any further read that falls inside a held line is answered in the same clock it is presented, so a burst of sequential words runs at one word per clock until it crosses into the next line.

Buffer contents are dropped whenever the state of the array changes. A program-data write, an erase interlock write, raising the high-voltage enable, clearing the sequence enable, or holding the system in reset clears both buffers. A change of the stop-interaction enable clears only the lower group's buffer.

Reads are refused while system reset is held, while the module is stopped, or while high voltage is applied without read access granted. A refused read completes at once with zero data and, if configured, an error flag. During margin-read phases a read returns the supplied operation status word in place of array data.

Top module: `fbb_ctrl`

## Requirements
- R1: After reset, both buffers are empty and `rd_ack` is low. The first read is therefore a miss.
- R2: A read that misses is acknowledged in clock 2 + `wait_cfg` (the request's first clock counts as clock 1). `arr_rd` is high throughout the fetch, and no acknowledge is given before the fetch completes.
- R3: A read that hits a valid buffer is acknowledged in the clock it is presented.
- R4: A line is four words. `rd_addr[1:0]` selects the word, and `rd_addr[AW-1:2]` is the line address. A read in a different line of the same group misses.
- R5: `rd_addr[AW-1]` = 0 selects the lower buffer and 1 selects the upper one. Each buffer keeps its line while the other is filled.
- R6: A one-clock pulse on `ev_prog_wr`, `ev_erase_lock`, `ev_hv_set` or `ev_seq_clr` invalidates both buffers. `sys_hold` does the same while it is high.
- R7: A pulse on `ev_sie_chg` invalidates the lower buffer only.
- R8: When `sys_hold`, or `stop_mode`, or (`hv_active` and not `access_en`) holds, a read is acknowledged in its first clock with zero data and `rd_err` = `err_sel`. Buffers are not filled. `hv_active` with `access_en` = 1 allows reads.
- R9: With `margin_mode` high and no refusal condition, a read is acknowledged in its first clock with `rd_data` = `op_status`, and neither buffer changes.
- R10: An invalidation of the target buffer in the clock its fill completes leaves it invalid, and the read refetches. A refusal or margin condition arising during a fetch aborts the fetch, and the read is then answered as refused or margin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_hold | input | 1 | System reset held: refuse reads, clear buffers |
| stop_mode | input | 1 | Module stopped: refuse reads |
| hv_active | input | 1 | High voltage applied to the array |
| access_en | input | 1 | Read access granted while high voltage is applied |
| margin_mode | input | 1 | Margin-read phase active |
| op_status | input | 32 | Status word returned during margin reads |
| err_sel | input | 1 | Refused reads raise `rd_err` |
| wait_cfg | input | 2 | Extra wait clocks on a miss |
| ev_prog_wr | input | 1 | Program-data write strobe |
| ev_erase_lock | input | 1 | Erase interlock write strobe |
| ev_hv_set | input | 1 | High-voltage enable set strobe |
| ev_seq_clr | input | 1 | Sequence enable cleared strobe |
| ev_sie_chg | input | 1 | Stop-interaction enable changed strobe |
| rd_req | input | 1 | Read request, held until acknowledged |
| rd_addr | input | AW | Word address of the read |
| rd_ack | output | 1 | Read completes this clock |
| rd_err | output | 1 | Bus-error response |
| rd_data | output | 32 | Read data |
| arr_rd | output | 1 | Array line read in progress |
| arr_line_addr | output | AW-2 | Line address presented to the array |
| arr_line | input | 128 | Line data returned by the array |

## Verification
Sequential words in a single line separate the one-clock hit path from the 2 + `wait_cfg` miss path. Alternating between the two address halves shows that the groups are independent. Each invalidation strobe is followed by reads in both halves, which tells a strobe that clears both buffers apart from one that clears only the lower buffer. Refusal and margin reads are aimed at both held and unheld lines, and a read follows each one, so a buffer that was filled or cleared by mistake shows up as a latency error. Seeded random mixes of addresses, wait settings, strobes and gating conditions are compared against a latency-and-data model in the bench. Directed cases place a strobe exactly on the fill clock and raise the stop condition mid-fetch.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } fbb_state_e;

    localparam int unsigned NUM_GROUPS = 2;
endpackage

// File: rtl/fbb_access_gate.sv
module fbb_access_gate (
    input  logic       sys_hold,
    input  logic       stop_mode,
    input  logic       hv_active,
    input  logic       access_en,
    input  logic       ev_prog_wr,
    input  logic       ev_erase_lock,
    input  logic       ev_hv_set,
    input  logic       ev_seq_clr,
    input  logic       ev_sie_chg,
    output logic       blocked,
    output logic [1:0] inv
);
    logic inv_all;

    always_comb begin
        blocked = sys_hold | stop_mode | (hv_active & ~access_en);
        inv_all = sys_hold | ev_prog_wr | ev_erase_lock | ev_hv_set | ev_seq_clr;
        inv[0]  = inv_all | ev_sie_chg;
        inv[1]  = inv_all;
    end
endmodule

// File: rtl/fbb_line_buf.sv
module fbb_line_buf #(
    parameter int unsigned TAG_W = 7,
    parameter int unsigned DW    = 32,
    parameter int unsigned WPL   = 4,
    localparam int unsigned OFS_W  = $clog2(WPL),
    localparam int unsigned LINE_W = DW * WPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              fill,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [LINE_W-1:0] fill_line,
    input  logic [TAG_W-1:0]  look_tag,
    input  logic [OFS_W-1:0]  look_ofs,
    output logic              hit,
    output logic [DW-1:0]     word
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (fill) begin
            buf_d.valid = 1'b1;
            buf_d.tag   = fill_tag;
            buf_d.line  = fill_line;
        end
        if (inv) begin
            buf_d.valid = 1'b0;
        end
        hit  = buf_q.valid && (buf_q.tag == look_tag);
        word = buf_q.line[look_ofs*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    // R6 / R7 / R10: an invalidation always leaves the line empty
    a_r6_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inv |=> !buf_q.valid);

    // R2: a fill without invalidation makes the fetched line valid
    a_r2_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !inv) |=> (buf_q.valid && buf_q.tag == $past(fill_tag)));
endmodule

// File: rtl/fbb_ctrl.sv
module fbb_ctrl #(
    parameter int unsigned AW  = 10,
    parameter int unsigned DW  = 32,
    parameter int unsigned WPL = 4,
    localparam int unsigned OFS_W  = $clog2(WPL),
    localparam int unsigned LA_W   = AW - OFS_W,
    localparam int unsigned TAG_W  = LA_W - 1,
    localparam int unsigned LINE_W = DW * WPL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_hold,
    input  logic              stop_mode,
    input  logic              hv_active,
    input  logic              access_en,
    input  logic              margin_mode,
    input  logic [DW-1:0]     op_status,
    input  logic              err_sel,
    input  logic [1:0]        wait_cfg,
    input  logic              ev_prog_wr,
    input  logic              ev_erase_lock,
    input  logic              ev_hv_set,
    input  logic              ev_seq_clr,
    input  logic              ev_sie_chg,
    input  logic              rd_req,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_ack,
    output logic              rd_err,
    output logic [DW-1:0]     rd_data,
    output logic              arr_rd,
    output logic [LA_W-1:0]   arr_line_addr,
    input  logic [LINE_W-1:0] arr_line
);
    import fbb_pkg::*;

    typedef struct packed {
        fbb_state_e      state;
        logic [1:0]      cnt;
        logic [LA_W-1:0] fla;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                 blocked;
    logic [1:0]           inv;
    logic [LA_W-1:0]      req_la;
    logic                 req_grp;
    logic [NUM_GROUPS-1:0] hit_v;
    logic [DW-1:0]        word_v [NUM_GROUPS];
    logic                 hit_sel;
    logic [DW-1:0]        word_sel;
    logic                 cap;
    logic [LA_W-1:0]      cap_la;
    logic [NUM_GROUPS-1:0] fill_v;

    assign req_la   = rd_addr[AW-1:OFS_W];
    assign req_grp  = req_la[LA_W-1];
    assign hit_sel  = hit_v[req_grp];
    assign word_sel = word_v[req_grp];

    fbb_access_gate i_gate (
        .sys_hold      (sys_hold),
        .stop_mode     (stop_mode),
        .hv_active     (hv_active),
        .access_en     (access_en),
        .ev_prog_wr    (ev_prog_wr),
        .ev_erase_lock (ev_erase_lock),
        .ev_hv_set     (ev_hv_set),
        .ev_seq_clr    (ev_seq_clr),
        .ev_sie_chg    (ev_sie_chg),
        .blocked       (blocked),
        .inv           (inv)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_buf
        assign fill_v[g] = cap && (cap_la[LA_W-1] == 1'(g));

        fbb_line_buf #(
            .TAG_W (TAG_W),
            .DW    (DW),
            .WPL   (WPL)
        ) i_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .inv       (inv[g]),
            .fill      (fill_v[g]),
            .fill_tag  (cap_la[TAG_W-1:0]),
            .fill_line (arr_line),
            .look_tag  (req_la[TAG_W-1:0]),
            .look_ofs  (rd_addr[OFS_W-1:0]),
            .hit       (hit_v[g]),
            .word      (word_v[g])
        );
    end

    always_comb begin
        ctl_d   = ctl_q;
        rd_ack  = 1'b0;
        rd_err  = 1'b0;
        rd_data = '0;
        cap     = 1'b0;
        cap_la  = req_la;
        arr_rd  = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (rd_req) begin
                    if (blocked) begin
                        rd_ack = 1'b1;
                        rd_err = err_sel;
                    end else if (margin_mode) begin
                        rd_ack  = 1'b1;
                        rd_data = op_status;
                    end else if (hit_sel) begin
                        rd_ack  = 1'b1;
                        rd_data = word_sel;
                    end else begin
                        arr_rd = 1'b1;
                        if (wait_cfg == 2'd0) begin
                            cap = 1'b1;
                        end else begin
                            ctl_d.state = ST_FETCH;
                            ctl_d.cnt   = 2'(wait_cfg - 2'd1);
                            ctl_d.fla   = req_la;
                        end
                    end
                end
            end
            ST_FETCH: begin
                cap_la = ctl_q.fla;
                arr_rd = 1'b1;
                if (blocked || margin_mode) begin
                    ctl_d.state = ST_IDLE;
                end else if (ctl_q.cnt == 2'd0) begin
                    cap         = 1'b1;
                    ctl_d.state = ST_IDLE;
                end else begin
                    ctl_d.cnt = 2'(ctl_q.cnt - 2'd1);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        arr_line_addr = cap_la;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cnt: 2'd0, fla: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R8: a refused read carries zero data and the configured error flag
    a_r8_refuse_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && blocked) |-> (rd_data == '0 && rd_err == err_sel));

    // R9: a margin read returns the status word without error
    a_r9_margin_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && margin_mode && !blocked) |-> (rd_data == op_status && !rd_err));

    // R2: no acknowledge while a line fetch is still running
    a_r2_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FETCH) |-> (!rd_ack && arr_rd));

    // R1: no acknowledge without a request
    a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> rd_req);

    // R5: at most one buffer is filled per clock
    a_r5_single_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_v));
endmodule

// File: tb/test_fbb_ctrl.sv
module test_fbb_ctrl;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sys_hold = 1'b0, stop_mode = 1'b0, hv_active = 1'b0, access_en = 1'b0;
    logic         margin_mode = 1'b0, err_sel = 1'b0;
    logic [31:0]  op_status = 32'h0;
    logic [1:0]   wait_cfg = 2'd0;
    logic         ev_prog_wr = 1'b0, ev_erase_lock = 1'b0, ev_hv_set = 1'b0;
    logic         ev_seq_clr = 1'b0, ev_sie_chg = 1'b0;
    logic         rd_req = 1'b0;
    logic [9:0]   rd_addr = 10'd0;
    logic         rd_ack, rd_err, arr_rd;
    logic [31:0]  rd_data;
    logic [7:0]   arr_line_addr;
    logic [127:0] arr_line;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit mvalid [2];
    int mtag   [2];

    fbb_ctrl i_fbb_ctrl (
        .clk(clk), .rst_n(rst_n), .sys_hold(sys_hold), .stop_mode(stop_mode),
        .hv_active(hv_active), .access_en(access_en), .margin_mode(margin_mode),
        .op_status(op_status), .err_sel(err_sel), .wait_cfg(wait_cfg),
        .ev_prog_wr(ev_prog_wr), .ev_erase_lock(ev_erase_lock), .ev_hv_set(ev_hv_set),
        .ev_seq_clr(ev_seq_clr), .ev_sie_chg(ev_sie_chg), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .arr_rd(arr_rd), .arr_line_addr(arr_line_addr), .arr_line(arr_line)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] arr_word(input logic [7:0] la, input logic [1:0] k);
        return (32'h9E3779B9 * {22'd0, la, k} + 32'h01234567) ^ {la, 24'd0};
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            arr_line[k*32 +: 32] = arr_word(arr_line_addr, 2'(k));
        end
    end

    function automatic bit is_blocked();
        return sys_hold | stop_mode | (hv_active & ~access_en);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_inv(input bit both);
        mvalid[0] = 1'b0;
        if (both) mvalid[1] = 1'b0;
    endtask

    // kind: 0 prog, 1 erase, 2 hv set, 3 seq clr, 4 sie change
    task automatic pulse_ev(input int kind);
        @(negedge clk);
        case (kind)
            0: ev_prog_wr = 1'b1;
            1: ev_erase_lock = 1'b1;
            2: ev_hv_set = 1'b1;
            3: ev_seq_clr = 1'b1;
            default: ev_sie_chg = 1'b1;
        endcase
        @(negedge clk);
        {ev_prog_wr, ev_erase_lock, ev_hv_set, ev_seq_clr, ev_sie_chg} = 5'b0;
        model_inv(kind != 4);
    endtask

    // evk: 0 none, 1 prog pulse at clock index evc, 2 stop raised at clock index evc
    task automatic do_read(input logic [9:0] a, input int evk, input int evc, input string req);
        int exp_lat;
        logic [31:0] exp_data;
        bit exp_err;
        int grp;
        int tg;
        int c;
        int lat;
        logic [31:0] got_d;
        bit got_e;
        grp = int'(a[9]);
        tg  = int'(a[8:2]);
        exp_err = 1'b0;
        if (evk == 1) begin
            exp_lat  = 2 * int'(wait_cfg) + 3;
            exp_data = arr_word(a[9:2], a[1:0]);
            model_inv(1'b1);
            mvalid[grp] = 1'b1;
            mtag[grp] = tg;
        end else if (evk == 2) begin
            exp_lat  = evc + 2;
            exp_data = 32'h0;
            exp_err  = err_sel;
        end else if (is_blocked()) begin
            exp_lat  = 1;
            exp_data = 32'h0;
            exp_err  = err_sel;
        end else if (margin_mode) begin
            exp_lat  = 1;
            exp_data = op_status;
        end else if (mvalid[grp] && mtag[grp] == tg) begin
            exp_lat  = 1;
            exp_data = arr_word(a[9:2], a[1:0]);
        end else begin
            exp_lat  = 2 + int'(wait_cfg);
            exp_data = arr_word(a[9:2], a[1:0]);
            mvalid[grp] = 1'b1;
            mtag[grp] = tg;
        end
        @(negedge clk);
        rd_addr = a;
        rd_req  = 1'b1;
        c = 0;
        lat = -1;
        got_d = 32'h0;
        got_e = 1'b0;
        forever begin
            if (evk == 1 && c == evc) ev_prog_wr = 1'b1;
            if (evk == 2 && c == evc) stop_mode = 1'b1;
            #1;
            if (rd_ack) begin
                lat = c + 1;
                got_d = rd_data;
                got_e = rd_err;
                break;
            end
            @(negedge clk);
            ev_prog_wr = 1'b0;
            c++;
            if (c > 40) break;
        end
        @(negedge clk);
        rd_req = 1'b0;
        ev_prog_wr = 1'b0;
        if (evk == 2) stop_mode = 1'b0;
        check(lat == exp_lat, req, "latency", lat, exp_lat);
        check(got_d == exp_data && got_e == exp_err, req, "data/err",
              {got_e, got_d}, {exp_err, exp_data});
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        mvalid[0] = 1'b0; mvalid[1] = 1'b0;
        mtag[0] = 0; mtag[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(rd_ack == 1'b0 && arr_rd == 1'b0, "R1", "idle after reset",
              {rd_ack, arr_rd}, 0);

        // R1 R2 R3 R4: fill then burst through the line
        wait_cfg = 2'd0;
        do_read(10'h005, 0, 0, "R1");
        do_read(10'h006, 0, 0, "R3");
        do_read(10'h004, 0, 0, "R4");
        do_read(10'h007, 0, 0, "R4");
        do_read(10'h008, 0, 0, "R4");
        // R2 R5: upper group with waits, lower group kept
        wait_cfg = 2'd3;
        do_read(10'h205, 0, 0, "R2");
        do_read(10'h209, 0, 0, "R5");
        do_read(10'h206, 0, 0, "R5");
        // R7: lower buffer only
        pulse_ev(4);
        do_read(10'h204, 0, 0, "R7");
        do_read(10'h00A, 0, 0, "R7");
        // R6: each strobe clears both
        for (int k = 0; k < 4; k++) begin
            wait_cfg = 2'(k);
            do_read(10'h00B, 0, 0, "R6");
            do_read(10'h207, 0, 0, "R6");
            pulse_ev(k);
            do_read(10'h00B, 0, 0, "R6");
            do_read(10'h207, 0, 0, "R6");
        end
        // R8: refusals, buffer kept
        wait_cfg = 2'd1;
        for (int e = 0; e < 2; e++) begin
            err_sel = 1'(e);
            stop_mode = 1'b1;
            do_read(10'h00B, 0, 0, "R8");
            do_read(10'h300, 0, 0, "R8");
            stop_mode = 1'b0;
            hv_active = 1'b1; access_en = 1'b0;
            do_read(10'h301, 0, 0, "R8");
            access_en = 1'b1;
            do_read(10'h00A, 0, 0, "R8");
            hv_active = 1'b0; access_en = 1'b0;
            do_read(10'h300, 0, 0, "R8");
        end
        @(negedge clk); sys_hold = 1'b1; model_inv(1'b1);
        do_read(10'h00A, 0, 0, "R8");
        @(negedge clk); sys_hold = 1'b0;
        do_read(10'h00A, 0, 0, "R6");
        err_sel = 1'b0;
        // R9: margin reads neither fill nor clear
        margin_mode = 1'b1; op_status = 32'hC0DE_5A71;
        do_read(10'h0F0, 0, 0, "R9");
        do_read(10'h009, 0, 0, "R9");
        margin_mode = 1'b0;
        do_read(10'h0F0, 0, 0, "R9");
        do_read(10'h009, 0, 0, "R9");
        // R10: strobe on fill clock, stop mid-fetch
        wait_cfg = 2'd0;
        do_read(10'h040, 1, 0, "R10");
        wait_cfg = 2'd2;
        do_read(10'h244, 1, 2, "R10");
        wait_cfg = 2'd3;
        do_read(10'h0C1, 2, 1, "R10");
        do_read(10'h0C1, 0, 0, "R10");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [9:0] a;
            int r;
            a = {1'($urandom_range(0, 1)), 5'd0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
            wait_cfg = 2'($urandom_range(0, 3));
            r = $urandom_range(0, 99);
            if (r < 12) pulse_ev($urandom_range(0, 4));
            @(negedge clk);
            stop_mode   = ($urandom_range(0, 99) < 10);
            hv_active   = ($urandom_range(0, 99) < 20);
            access_en   = ($urandom_range(0, 1) == 1);
            margin_mode = ($urandom_range(0, 99) < 10);
            err_sel     = ($urandom_range(0, 1) == 1);
            op_status   = $urandom;
            sys_hold    = ($urandom_range(0, 99) < 5);
            if (sys_hold) model_inv(1'b1);
            do_read(a, 0, 0, "R4");
            sys_hold = 1'b0;
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule